// File: doc/BRIEF.md
# Linear Ramped FSK Tuning-Word Sweeper

This block feeds the frequency tuning word to a numerically controlled oscillator. It holds two endpoint tuning words. A single FSK input picks which endpoint is the current target. In ramp mode the block does not jump to the target. It walks its registered output toward the target in equal increments. One increment is taken each time a programmable dwell counter expires, so the frequency moves along a straight line.

The step size and the dwell count may be rewritten while a sweep is running, which produces piecewise-linear frequency profiles. The output never passes the target. It is clamped onto the target and then held there, and a done flag is raised while the output sits on the target. The output register only ever moves from its present value, so the oscillator never sees a discontinuity that would break phase continuity. This holds when the FSK input reverses mid-sweep and when the block enters ramp mode.

The block also has two non-swept modes: a fixed tone, and plain FSK switching between the endpoints.

Top module: `fsk_ramp_gen`

## Requirements
- R1: While `rst_ni` is low and after its release until the first clock edge, `ftw_o` is 0.
- R2: With `mode_i` = 3'b000 (fixed tone), `ftw_o` takes the value of `ftw1_i` one clock after it is sampled, and `fsk_i` has no effect on it.
- R3: With `mode_i` = 3'b001 (plain FSK), `ftw_o` takes `ftw1_i` when `fsk_i` is 0 and `ftw2_i` when `fsk_i` is 1, one clock after sampling.
- R4: With `mode_i` = 3'b010 (ramp), the target is `ftw1_i` when `fsk_i` is 0 and `ftw2_i` when `fsk_i` is 1.
- R5: In ramp mode a dwell counter expires on the first ramp clock and then once every `rate_i`+1 clocks. At each expiry `ftw_o` moves toward the target by exactly `step_i`. Between expiries `ftw_o` holds its value.
- R6: An expiry whose remaining distance is not larger than `step_i` sets `ftw_o` exactly to the target. `ftw_o` never passes the target, even next to 0 or to the all-ones word.
- R7: `done_o` is 1 exactly when the mode is ramp and `ftw_o` equals the present target. While it is 1 and the target does not change, `ftw_o` holds.
- R8: When `fsk_i` reverses during a sweep, the sweep turns around from the present `ftw_o`, and the first move after the reversal is one step at the next expiry.
- R9: `rate_i` is captured only when the counter reloads at an expiry. `step_i` is used only at an expiry. Changing either between expiries does not alter the dwell that is already running.
- R10: On entry to ramp mode the sweep starts from the `ftw_o` value held at that moment.
- R11: `mode_i` codes 3'b011 to 3'b111 behave as the fixed-tone mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| fsk_i | input | 1 | Endpoint select |
| ftw1_i | input | FTW_W | First endpoint tuning word |
| ftw2_i | input | FTW_W | Second endpoint tuning word |
| step_i | input | FTW_W | Increment applied at each expiry |
| rate_i | input | RATE_W | Dwell count reloaded at each expiry |
| ftw_o | output | FTW_W | Current tuning word |
| done_o | output | 1 | Output equals the ramp target |

## Verification
The bench builds the block with the full 48-bit tuning word and with an 8-bit dwell count. The narrow dwell count keeps dwells short, so thousands of expiries, turnarounds and mid-sweep reloads fit in a short run. Because the tuning word keeps its full width, the bench can sweep between 0 and the all-ones word with steps of half the range. That exercises clamping at both numeric extremes without wraparound.

// File: rtl/fsk_ramp_pkg.sv
package fsk_ramp_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_TONE = 3'b000,
    MODE_FSK  = 3'b001,
    MODE_RAMP = 3'b010
  } mode_e;
endpackage

// File: rtl/fsk_ramp_timer.sv
module fsk_ramp_timer #(
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  // idle counter parks at zero so the first ramp clock expires at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= rate_i;
    else              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/fsk_ramp_stepper.sv
module fsk_ramp_stepper #(
  parameter int unsigned FTW_W = 48
) (
  input  logic [FTW_W-1:0] cur_i,
  input  logic [FTW_W-1:0] tgt_i,
  input  logic [FTW_W-1:0] step_i,
  output logic [FTW_W-1:0] nxt_o
);
  logic             up;
  logic [FTW_W-1:0] gap;

  assign up  = tgt_i > cur_i;
  assign gap = up ? (tgt_i - cur_i) : (cur_i - tgt_i);

  // clamp on target when within one step; otherwise no wrap is possible
  always_comb begin
    if (gap <= step_i) nxt_o = tgt_i;
    else if (up)       nxt_o = cur_i + step_i;
    else               nxt_o = cur_i - step_i;
  end
endmodule

// File: rtl/fsk_ramp_gen.sv
module fsk_ramp_gen
  import fsk_ramp_pkg::*;
#(
  parameter int unsigned FTW_W  = 48,
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              fsk_i,
  input  logic [FTW_W-1:0]  ftw1_i,
  input  logic [FTW_W-1:0]  ftw2_i,
  input  logic [FTW_W-1:0]  step_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [FTW_W-1:0]  ftw_o,
  output logic              done_o
);
  logic             ramp_en;
  logic             tick_w;
  logic [FTW_W-1:0] tgt_w;
  logic [FTW_W-1:0] direct_w;
  logic [FTW_W-1:0] step_nxt;
  logic [FTW_W-1:0] cur_q;
  logic [FTW_W-1:0] cur_d;

  assign ramp_en  = (mode_i == MODE_RAMP);
  assign tgt_w    = fsk_i ? ftw2_i : ftw1_i;
  assign direct_w = ((mode_i == MODE_FSK) && fsk_i) ? ftw2_i : ftw1_i;

  fsk_ramp_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ramp_en),
    .rate_i (rate_i),
    .tick_o (tick_w)
  );

  fsk_ramp_stepper #(.FTW_W(FTW_W)) u_step (
    .cur_i  (cur_q),
    .tgt_i  (tgt_w),
    .step_i (step_i),
    .nxt_o  (step_nxt)
  );

  always_comb begin
    if (!ramp_en)    cur_d = direct_w;
    else if (tick_w) cur_d = step_nxt;
    else             cur_d = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign ftw_o  = cur_q;
  assign done_o = ramp_en && (cur_q == tgt_w);
endmodule

// File: rtl/fsk_ramp_chk.sv
module fsk_ramp_chk
  import fsk_ramp_pkg::*;
#(
  parameter int unsigned FTW_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              fsk_i,
  input logic [FTW_W-1:0]  ftw1_i,
  input logic [FTW_W-1:0]  ftw2_i,
  input logic [FTW_W-1:0]  step_i,
  input logic [FTW_W-1:0]  ftw_o,
  input logic              done_o,
  input logic [FTW_W-1:0]  tgt_w,
  input logic              tick_w
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_tone_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_TONE) |-> ftw_o == $past(ftw1_i));

  assert_fsk_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_FSK) |-> ftw_o == $past(fsk_i ? ftw2_i : ftw1_i));

  assert_step_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_RAMP) |->
      ((($past(ftw_o) > ftw_o) ? ($past(ftw_o) - ftw_o) : (ftw_o - $past(ftw_o))) <= $past(step_i)));

  assert_move_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_RAMP) && (ftw_o != $past(ftw_o)) |-> $past(tick_w));

  assert_no_overshoot_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_RAMP) && ($past(ftw_o) <= $past(tgt_w)) |-> ftw_o <= $past(tgt_w));

  assert_no_overshoot_dn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && ($past(mode_i) == MODE_RAMP) && ($past(ftw_o) >= $past(tgt_w)) |-> ftw_o >= $past(tgt_w));

  assert_hold_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(done_o) |-> ftw_o == $past(ftw_o));
endmodule

bind fsk_ramp_gen fsk_ramp_chk #(.FTW_W(FTW_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .fsk_i  (fsk_i),
  .ftw1_i (ftw1_i),
  .ftw2_i (ftw2_i),
  .step_i (step_i),
  .ftw_o  (ftw_o),
  .done_o (done_o),
  .tgt_w  (tgt_w),
  .tick_w (tick_w)
);

// File: tb/sim_fsk_ramp_gen.sv
module sim_fsk_ramp_gen;
  localparam int unsigned FTW_W  = 48;
  localparam int unsigned RATE_W = 8;
  localparam logic [FTW_W-1:0] ONES = '1;
  localparam logic [FTW_W-1:0] HALF = {1'b1, {(FTW_W-1){1'b0}}};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        mode = 3'b000;
  logic              fsk = 1'b0;
  logic [FTW_W-1:0]  ftw1 = '0;
  logic [FTW_W-1:0]  ftw2 = '0;
  logic [FTW_W-1:0]  step = '0;
  logic [RATE_W-1:0] rate = '0;
  logic [FTW_W-1:0]  ftw_o;
  logic              done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [FTW_W-1:0]  m_cur = '0;
  logic [RATE_W-1:0] m_cnt = '0;

  always #10ns clk = ~clk;

  fsk_ramp_gen #(.FTW_W(FTW_W), .RATE_W(RATE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .fsk_i(fsk),
    .ftw1_i(ftw1), .ftw2_i(ftw2), .step_i(step), .rate_i(rate),
    .ftw_o(ftw_o), .done_o(done_o)
  );

  function automatic logic [FTW_W-1:0] step_f(logic [FTW_W-1:0] c, logic [FTW_W-1:0] t,
                                              logic [FTW_W-1:0] s);
    logic [FTW_W-1:0] g;
    g = (t > c) ? t - c : c - t;
    if (g <= s) return t;
    return (t > c) ? c + s : c - s;
  endfunction

  task automatic chk(bit ok, string req, logic [FTW_W-1:0] act, logic [FTW_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: reference update at the edge, comparison at the falling edge
  task automatic cyc(string req);
    logic [FTW_W-1:0] tgt;
    bit exp_done;
    @(posedge clk);
    tgt = fsk ? ftw2 : ftw1;
    if (mode != 3'b010) begin
      m_cnt = '0;
      m_cur = (mode == 3'b001 && fsk) ? ftw2 : ftw1;
    end else if (m_cnt == '0) begin
      m_cnt = rate;
      m_cur = step_f(m_cur, tgt, step);
    end else begin
      m_cnt = m_cnt - 1'b1;
    end
    @(negedge clk);
    chk(ftw_o === m_cur, req, ftw_o, m_cur);
    exp_done = (mode == 3'b010) && (m_cur == tgt);
    chk(done_o === exp_done, "R7", {{(FTW_W-1){1'b0}}, done_o}, {{(FTW_W-1){1'b0}}, exp_done});
  endtask

  task automatic cycn(int n, string req);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ftw1 = 48'd77; mode = 3'b010;
    #35ns;
    chk(ftw_o === '0, "R1", ftw_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    chk(ftw_o === '0, "R1", ftw_o, '0);

    // R2 / R11: tone mode, fsk ignored
    mode = 3'b000; fsk = 1'b1; ftw1 = 48'h1234_5678_9ABC; ftw2 = 48'h5;
    cyc("R2");
    chk(ftw_o === 48'h1234_5678_9ABC, "R2", ftw_o, 48'h1234_5678_9ABC);
    mode = 3'b111; ftw1 = 48'hABC;
    cyc("R11");
    chk(ftw_o === 48'hABC, "R11", ftw_o, 48'hABC);

    // R3: plain FSK
    mode = 3'b001; fsk = 1'b1;
    cyc("R3");
    chk(ftw_o === 48'h5, "R3", ftw_o, 48'h5);
    fsk = 1'b0;
    cyc("R3");
    chk(ftw_o === 48'hABC, "R3", ftw_o, 48'hABC);

    // R4/R5/R6: ramp 1000 -> 1030, step 7, dwell 3 clocks
    ftw1 = 48'd1000; ftw2 = 48'd1030;
    cyc("R3");
    mode = 3'b010; fsk = 1'b1; step = 48'd7; rate = 8'd2;
    cyc("R5");
    chk(ftw_o === 48'd1007, "R5", ftw_o, 48'd1007);
    cycn(2, "R5");
    chk(ftw_o === 48'd1007, "R5", ftw_o, 48'd1007);
    cyc("R5");
    chk(ftw_o === 48'd1014, "R4", ftw_o, 48'd1014);
    cycn(9, "R6");
    chk(ftw_o === 48'd1030, "R6", ftw_o, 48'd1030);
    chk(done_o === 1'b1, "R7", {{(FTW_W-1){1'b0}}, done_o}, 48'd1);

    // R8: reverse, then reverse again mid-sweep
    fsk = 1'b0;
    cycn(2, "R8");
    chk(done_o === 1'b0, "R7", {{(FTW_W-1){1'b0}}, done_o}, 48'd0);
    cyc("R8");
    chk(ftw_o === 48'd1023, "R8", ftw_o, 48'd1023);
    cycn(3, "R8");
    chk(ftw_o === 48'd1016, "R8", ftw_o, 48'd1016);
    fsk = 1'b1;
    cycn(3, "R8");
    chk(ftw_o === 48'd1023, "R8", ftw_o, 48'd1023);

    // R9: reload between expiries does not disturb the running dwell
    rate = 8'd0; step = 48'd2;
    cycn(2, "R9");
    chk(ftw_o === 48'd1023, "R9", ftw_o, 48'd1023);
    cyc("R9");
    chk(ftw_o === 48'd1025, "R9", ftw_o, 48'd1025);
    cyc("R9");
    chk(ftw_o === 48'd1027, "R9", ftw_o, 48'd1027);

    // R10: entry to ramp starts from the held value
    mode = 3'b000; ftw1 = 48'd500;
    cyc("R2");
    mode = 3'b010; ftw2 = 48'd600; step = 48'd1; rate = 8'd0;
    cyc("R10");
    chk(ftw_o === 48'd501, "R10", ftw_o, 48'd501);

    // R6: extremes of the word, half-range steps
    mode = 3'b001; fsk = 1'b0; ftw1 = '0; ftw2 = ONES;
    cyc("R3");
    mode = 3'b010; fsk = 1'b1; step = HALF;
    cyc("R6");
    chk(ftw_o === HALF, "R6", ftw_o, HALF);
    cyc("R6");
    chk(ftw_o === ONES, "R6", ftw_o, ONES);
    fsk = 1'b0;
    cyc("R6");
    chk(ftw_o === HALF - 1'b1, "R6", ftw_o, HALF - 1'b1);
    cyc("R6");
    chk(ftw_o === '0, "R6", ftw_o, '0);

    // constrained random segments
    for (int seg = 0; seg < 120; seg++) begin
      int r;
      r = $urandom_range(0, 9);
      mode = (r < 7) ? 3'b010 : (r == 7) ? 3'b001 : (r == 8) ? 3'b000 : 3'($urandom_range(3, 7));
      ftw1 = 48'($urandom_range(0, 65535));
      ftw2 = (seg % 10 == 0) ? ONES - 48'($urandom_range(0, 999)) : 48'($urandom_range(0, 65535));
      step = (seg % 10 == 0) ? {2'b01, 46'($urandom)} : 48'($urandom_range(1, 400));
      rate = 8'($urandom_range(0, 7));
      for (int k = 0; k < 60; k++) begin
        if ($urandom_range(0, 19) == 0) fsk = ~fsk;
        if ($urandom_range(0, 29) == 0) rate = 8'($urandom_range(0, 7));
        if ($urandom_range(0, 29) == 0) step = 48'($urandom_range(1, 400));
        cyc(mode == 3'b010 ? "R5" : mode == 3'b001 ? "R3" : mode == 3'b000 ? "R2" : "R11");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule